// File: doc/BRIEF.md
# Multi-Mode Effective Address Generator

This block forms the operand address for a load unit that handles a rich set of addressing modes. For each request it takes a mode code, an instruction field, a base value, an index value, a program counter value, a scale code, an access-size code and two signed displacements. It returns either an immediate operand or a 32-bit effective address. Register-based and PC-based modes finish in one cycle. The memory-indirect modes first issue a read to fetch an intermediate pointer and then finish the address from that pointer.

Requests enter on a valid/ready handshake. `req_ready` is high only while the block is idle. The block samples every request field in the accepting cycle, so the caller may change them freely afterwards. Results leave on a valid/ready handshake: `out_valid` stays high and `out_value`/`out_is_addr` stay stable until `out_ready` is seen. The pointer read is a valid/ready request followed by a response strobe. `mem_req_addr` stays stable until `mem_req_ready`. Only a response that arrives after the request handshake is used. The predecrement mode reports the new base value on a one-cycle writeback strobe.

Top module: `ea_gen`

## Requirements
- R1: After reset the block is idle: `req_ready`=1 and `out_valid`, `mem_req_valid` and `wb_valid` are 0.
- R2: Mode 0, and every code from 10 to 15, returns `req_field` unchanged with `out_is_addr`=0. `out_valid` rises in the cycle after acceptance.
- R3: Mode 1 (register direct) and mode 2 (memory direct) return `req_field` as the address, with `out_is_addr`=1 and one-cycle latency.
- R4: Mode 3 (register indirect) returns `req_base`.
- R5: Mode 4 (predecrement) returns base minus the step, where the step is 1, 2 or 4 for `req_size` codes 0, 1 and 2, and 4 for code 3. In the first cycle of `out_valid`, `wb_valid` pulses for exactly one cycle with `wb_data` equal to the result. No other mode raises `wb_valid`.
- R6: Mode 5 (indexed) returns base + disp1 + index×S, where S is 1, 2 or 4 for `req_scale` codes 0, 1 and 2, and 4 for code 3.
- R7: Mode 9 (PC-relative indexed) returns pc + disp1 + index×S.
- R8: Mode 6 (memory indirect) reads at base + disp1 and returns pointer + disp2. No result is presented before the read response.
- R9: Mode 7 (memory indirect, index after fetch) reads at base + disp1 and returns pointer + disp2 + index×S.
- R10: Mode 8 (memory indirect, index before fetch) reads at base + disp1 + index×S and returns pointer + disp2.
- R11: Displacements are sign-extended from `DW` bits, and all address sums wrap modulo 2^32.
- R12: `req_ready` is low while a result or a read is outstanding. `out_value` and `out_is_addr` hold while `out_valid` waits for `out_ready`. `mem_req_addr` holds while `mem_req_valid` waits for `mem_req_ready`.
- R13: Request inputs that change after acceptance have no effect on the result, the read address or the writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken this cycle if valid |
| req_mode | input | 4 | Addressing mode code |
| req_field | input | AW | Immediate or direct address from the instruction |
| req_base | input | AW | Base register value |
| req_index | input | AW | Index register value |
| req_pc | input | AW | Program counter value |
| req_scale | input | 2 | Index scale code |
| req_size | input | 2 | Access size code for predecrement |
| req_disp1 | input | DW | First signed displacement |
| req_disp2 | input | DW | Second signed displacement |
| mem_req_valid | output | 1 | Pointer read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | AW | Pointer read address |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | AW | Pointer read back |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_value | output | AW | Operand or effective address |
| out_is_addr | output | 1 | 1 when out_value is an address |
| wb_valid | output | 1 | Base writeback strobe |
| wb_data | output | AW | Updated base value |

## Verification
Every mode is driven, and each result is compared against a reference built from wide integer sums, so a wrong operand selection, a missing term or a misplaced index shows up as a value mismatch. The scale and size codes are swept over all four values with the same base, which separates the shift decoding from the adder. Negative displacements and bases near the top of the address space separate sign extension and wrap-around from plain addition. Indirect requests use read and output stalls of different lengths, and all request inputs are scrambled after acceptance. This exposes any late sampling, any premature result and any lost hold under back-pressure.

// File: rtl/eag_pkg.sv
package eag_pkg;
  typedef enum logic [3:0] {
    M_IMM   = 4'd0,
    M_RDIR  = 4'd1,
    M_MDIR  = 4'd2,
    M_RIND  = 4'd3,
    M_PDEC  = 4'd4,
    M_IDX   = 4'd5,
    M_MIND  = 4'd6,
    M_MPOST = 4'd7,
    M_MPRE  = 4'd8,
    M_PCREL = 4'd9
  } mode_e;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_RSP, S_OUT} st_e;

  // byte count for a size or scale code: 1, 2, 4, 4
  function automatic logic [2:0] code_bytes(input logic [1:0] code);
    case (code)
      2'd0:    code_bytes = 3'd1;
      2'd1:    code_bytes = 3'd2;
      default: code_bytes = 3'd4;
    endcase
  endfunction

  function automatic logic [1:0] code_shift(input logic [1:0] code);
    case (code)
      2'd0:    code_shift = 2'd0;
      2'd1:    code_shift = 2'd1;
      default: code_shift = 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/eag_sext.sv
module eag_sext #(
  parameter int IW = 16,
  parameter int OW = 32
) (
  input  logic [IW-1:0] d,
  output logic [OW-1:0] q
);
  generate
    if (OW > IW) begin : g_ext
      assign q = {{(OW-IW){d[IW-1]}}, d};
    end else begin : g_cut
      assign q = d[OW-1:0];
    end
  endgenerate
endmodule

// File: rtl/eag_front.sv
module eag_front
  import eag_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [3:0]    mode,
  input  logic [AW-1:0] field,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] index,
  input  logic [AW-1:0] pc,
  input  logic [1:0]    scale,
  input  logic [1:0]    size,
  input  logic [AW-1:0] disp1,
  output logic [AW-1:0] val,
  output logic [AW-1:0] scaled,
  output logic          ind,
  output logic          imm,
  output logic          post,
  output logic          pdec
);
  logic [AW-1:0] step;
  logic [AW-1:0] base_d1;

  assign scaled  = index << code_shift(scale);
  assign step    = AW'(code_bytes(size));
  assign base_d1 = base + disp1;

  always_comb begin
    val  = field;
    ind  = 1'b0;
    imm  = 1'b0;
    post = 1'b0;
    pdec = 1'b0;
    case (mode)
      M_RDIR, M_MDIR: val = field;
      M_RIND:  val = base;
      M_PDEC:  begin val = base - step; pdec = 1'b1; end
      M_IDX:   val = base_d1 + scaled;
      M_PCREL: val = pc + disp1 + scaled;
      M_MIND:  begin val = base_d1; ind = 1'b1; end
      M_MPOST: begin val = base_d1; ind = 1'b1; post = 1'b1; end
      M_MPRE:  begin val = base_d1 + scaled; ind = 1'b1; end
      default: begin val = field; imm = 1'b1; end
    endcase
  end
endmodule

// File: rtl/eag_ctrl.sv
module eag_ctrl
  import eag_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic ind,
  input  logic mem_req_ready,
  input  logic mem_rsp_valid,
  input  logic out_ready,
  output logic req_ready,
  output logic mem_req_valid,
  output logic out_valid,
  output logic take_req,
  output logic take_rsp
);
  st_e st, nx;

  assign req_ready     = (st == S_IDLE);
  assign mem_req_valid = (st == S_REQ);
  assign out_valid     = (st == S_OUT);
  assign take_req      = req_ready & req_valid;
  assign take_rsp      = (st == S_RSP) & mem_rsp_valid;

  always_comb begin
    nx = st;
    case (st)
      S_IDLE: if (req_valid) nx = ind ? S_REQ : S_OUT;
      S_REQ:  if (mem_req_ready) nx = S_RSP;
      S_RSP:  if (mem_rsp_valid) nx = S_OUT;
      S_OUT:  if (out_ready) nx = S_IDLE;
      default: nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= S_IDLE;
    else        st <= nx;
  end
endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import eag_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [3:0]    req_mode,
  input  logic [AW-1:0] req_field,
  input  logic [AW-1:0] req_base,
  input  logic [AW-1:0] req_index,
  input  logic [AW-1:0] req_pc,
  input  logic [1:0]    req_scale,
  input  logic [1:0]    req_size,
  input  logic [DW-1:0] req_disp1,
  input  logic [DW-1:0] req_disp2,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [AW-1:0] mem_rsp_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_value,
  output logic          out_is_addr,
  output logic          wb_valid,
  output logic [AW-1:0] wb_data
);
  logic [AW-1:0] d1x, d2x;
  logic [AW-1:0] f_val, f_scaled;
  logic          f_ind, f_imm, f_post, f_pdec;
  logic          take_req, take_rsp;

  logic [AW-1:0] val_q, d2_q, padd_q, wbd_q;
  logic          addr_q, wb_q;

  eag_sext #(.IW(DW), .OW(AW)) u_sx1 (.d(req_disp1), .q(d1x));
  eag_sext #(.IW(DW), .OW(AW)) u_sx2 (.d(req_disp2), .q(d2x));

  eag_front #(.AW(AW)) u_front (
    .mode(req_mode), .field(req_field), .base(req_base), .index(req_index),
    .pc(req_pc), .scale(req_scale), .size(req_size), .disp1(d1x),
    .val(f_val), .scaled(f_scaled), .ind(f_ind), .imm(f_imm),
    .post(f_post), .pdec(f_pdec)
  );

  eag_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .ind(f_ind),
    .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
    .out_ready(out_ready), .req_ready(req_ready),
    .mem_req_valid(mem_req_valid), .out_valid(out_valid),
    .take_req(take_req), .take_rsp(take_rsp)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q  <= '0;
      d2_q   <= '0;
      padd_q <= '0;
      wbd_q  <= '0;
      addr_q <= 1'b0;
      wb_q   <= 1'b0;
    end else begin
      wb_q <= take_req & f_pdec;
      if (take_req) begin
        val_q  <= f_val;
        addr_q <= ~f_imm;
        d2_q   <= d2x;
        padd_q <= f_post ? f_scaled : '0;
        if (f_pdec) wbd_q <= f_val;
      end else if (take_rsp) begin
        val_q  <= mem_rsp_data + d2_q + padd_q;
        addr_q <= 1'b1;
      end
    end
  end

  assign mem_req_addr = val_q;
  assign out_value    = val_q;
  assign out_is_addr  = addr_q;
  assign wb_valid     = wb_q;
  assign wb_data      = wbd_q;
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk
  import eag_pkg::*;
#(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [3:0]    req_mode,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic [AW-1:0] mem_req_addr,
  input logic          out_valid,
  input logic          out_ready,
  input logic [AW-1:0] out_value,
  input logic          out_is_addr,
  input logic          wb_valid,
  input logic [AW-1:0] wb_data
);
  logic acc, ind_m;
  assign acc   = req_valid && req_ready;
  assign ind_m = (req_mode == M_MIND) || (req_mode == M_MPOST) || (req_mode == M_MPRE);

  a_r12_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_value) && $stable(out_is_addr));

  a_r12_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  a_r12_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid || mem_req_valid) |-> !req_ready);

  a_r12_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && mem_req_valid));

  a_r2_fast: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !ind_m |=> out_valid);

  a_r8_read_first: assert property (@(posedge clk) disable iff (!rst_n)
    acc && ind_m |=> mem_req_valid && !out_valid);

  a_r5_wb_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |=> !wb_valid);

  a_r5_wb_only_pdec: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (req_mode != M_PDEC) |=> !wb_valid);

  a_r5_wb_match: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> out_valid && (out_value == wb_data));
endmodule

bind ea_gen ea_gen_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_mode(req_mode), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .out_valid(out_valid), .out_ready(out_ready),
  .out_value(out_value), .out_is_addr(out_is_addr), .wb_valid(wb_valid),
  .wb_data(wb_data)
);

// File: tb/ea_gen_test.sv
module ea_gen_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_mode = '0;
  logic [31:0] req_field = '0, req_base = '0, req_index = '0, req_pc = '0;
  logic [1:0]  req_scale = '0, req_size = '0;
  logic [15:0] req_disp1 = '0, req_disp2 = '0;
  logic        mem_req_valid, mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        out_valid, out_ready = 1'b0, out_is_addr;
  logic [31:0] out_value;
  logic        wb_valid;
  logic [31:0] wb_data;

  int total = 0;
  int bad = 0;
  bit busy = 0;
  bit mon_on = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ea_gen #(.AW(32), .DW(16)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_field(req_field), .req_base(req_base),
    .req_index(req_index), .req_pc(req_pc), .req_scale(req_scale),
    .req_size(req_size), .req_disp1(req_disp1), .req_disp2(req_disp2),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_value(out_value), .out_is_addr(out_is_addr), .wb_valid(wb_valid),
    .wb_data(wb_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // memory content seen by pointer reads
  function automatic logic [31:0] mem_word(input logic [31:0] a);
    logic [63:0] t;
    t = longint'(a) * 3 + 64'h1357;
    return t[31:0];
  endfunction

  // behavioural reference: wide integer sums truncated to 32 bits
  task automatic ref_op(input int m, input logic [31:0] fld, input logic [31:0] base,
                        input logic [31:0] idx, input logic [31:0] pc, input int sc, input int sz,
                        input logic [15:0] d1, input logic [15:0] d2,
                        output bit ind, output logic [31:0] raddr,
                        output logic [31:0] res, output bit isaddr, output bit pd);
    longint s1, s2, mul, step;
    logic [63:0] t;
    s1 = longint'($signed(d1));
    s2 = longint'($signed(d2));
    mul = (sc == 0) ? 1 : (sc == 1) ? 2 : 4;
    step = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    ind = 0; raddr = '0; isaddr = 1; pd = 0; res = fld;
    case (m)
      1, 2: res = fld;
      3: res = base;
      4: begin t = longint'(base) - step; res = t[31:0]; pd = 1; end
      5: begin t = longint'(base) + s1 + longint'(idx) * mul; res = t[31:0]; end
      9: begin t = longint'(pc) + s1 + longint'(idx) * mul; res = t[31:0]; end
      6, 7, 8: begin
        ind = 1;
        t = longint'(base) + s1 + ((m == 8) ? longint'(idx) * mul : 0);
        raddr = t[31:0];
        t = longint'(mem_word(raddr)) + s2 + ((m == 7) ? longint'(idx) * mul : 0);
        res = t[31:0];
      end
      default: begin res = fld; isaddr = 0; end
    endcase
  endtask

  // per-clock comparison of handshake state against the model's busy flag (R12)
  always @(negedge clk) begin
    if (mon_on) begin
      chk("R12 req_ready vs model", {31'b0, req_ready}, {31'b0, !busy});
      if (!busy) chk("R12 idle outputs", {30'b0, out_valid, mem_req_valid}, 32'd0);
    end
  end

  task automatic do_op(input string tag, input int m, input logic [31:0] fld,
                       input logic [31:0] base, input logic [31:0] idx, input logic [31:0] pc,
                       input int sc, input int sz, input logic [15:0] d1, input logic [15:0] d2,
                       input int rd_wait, input int rsp_wait, input int out_wait);
    bit ind, isaddr, pd;
    logic [31:0] raddr, res;
    ref_op(m, fld, base, idx, pc, sc, sz, d1, d2, ind, raddr, res, isaddr, pd);
    @(negedge clk);
    chk({tag, " ready before request"}, {31'b0, req_ready}, 32'd1);
    req_valid = 1'b1; req_mode = 4'(m); req_field = fld; req_base = base;
    req_index = idx; req_pc = pc; req_scale = 2'(sc); req_size = 2'(sz);
    req_disp1 = d1; req_disp2 = d2;
    @(posedge clk);
    busy = 1;
    @(negedge clk);
    // scramble every request input after acceptance (R13)
    req_valid = 1'b0; req_mode = 4'd4; req_field = ~fld; req_base = ~base;
    req_index = idx + 32'd7; req_pc = pc ^ 32'hFFFF; req_scale = 2'(sc + 1);
    req_size = 2'(sz + 1); req_disp1 = ~d1; req_disp2 = ~d2;
    if (ind) begin
      chk({tag, " read issued"}, {30'b0, mem_req_valid, out_valid}, 32'd2);
      chk({tag, " read addr R13"}, mem_req_addr, raddr);
      for (int i = 0; i < rd_wait; i++) begin
        @(negedge clk);
        chk({tag, " R12 read addr held"}, mem_req_addr, raddr);
      end
      mem_req_ready = 1'b1;
      @(negedge clk);
      mem_req_ready = 1'b0;
      chk({tag, " read dropped, no early result"}, {30'b0, mem_req_valid, out_valid}, 32'd0);
      for (int i = 0; i < rsp_wait; i++) begin
        @(negedge clk);
        chk({tag, " no result before response"}, {31'b0, out_valid}, 32'd0);
      end
      mem_rsp_valid = 1'b1; mem_rsp_data = mem_word(raddr);
      @(negedge clk);
      mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    end else begin
      chk({tag, " R5 wb strobe"}, {31'b0, wb_valid}, {31'b0, pd});
      if (pd) chk({tag, " R5 wb data"}, wb_data, res);
    end
    chk({tag, " out_valid"}, {31'b0, out_valid}, 32'd1);
    chk({tag, " value R13"}, out_value, res);
    chk({tag, " is_addr"}, {31'b0, out_is_addr}, {31'b0, isaddr});
    for (int i = 0; i < out_wait; i++) begin
      @(negedge clk);
      chk({tag, " R12 result held"}, {out_valid, out_value[30:0]}, {1'b1, res[30:0]});
      chk({tag, " R5 wb single pulse"}, {31'b0, wb_valid}, 32'd0);
    end
    out_ready = 1'b1;
    @(posedge clk);
    busy = 0;
    @(negedge clk);
    out_ready = 1'b0;
    chk({tag, " out dropped"}, {31'b0, out_valid}, 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 in reset", {28'b0, req_ready, out_valid, mem_req_valid, wb_valid}, 32'h8);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", {28'b0, req_ready, out_valid, mem_req_valid, wb_valid}, 32'h8);
    mon_on = 1;

    do_op("R2 imm",        0, 32'hDEADBEEF, 32'h1, 32'h2, 32'h3, 0, 0, 16'h5, 16'h6, 0, 0, 0);
    do_op("R2 code 13",   13, 32'h12345678, 32'h1, 32'h2, 32'h3, 1, 1, 16'h5, 16'h6, 0, 0, 1);
    do_op("R3 reg direct", 1, 32'h00000007, 32'h11, 32'h2, 32'h3, 0, 0, 16'h5, 16'h6, 0, 0, 0);
    do_op("R3 mem direct", 2, 32'h80002000, 32'h11, 32'h2, 32'h3, 0, 0, 16'h5, 16'h6, 0, 0, 0);
    do_op("R4 reg ind",    3, 32'h0, 32'h40000010, 32'h2, 32'h3, 0, 0, 16'h5, 16'h6, 0, 0, 0);
    for (int s = 0; s < 4; s++)
      do_op("R5 predec",   4, 32'h0, 32'h00000100, 32'h9, 32'h3, 0, s, 16'h5, 16'h6, 0, 0, 1);
    do_op("R11 predec wrap", 4, 32'h0, 32'h00000002, 32'h9, 32'h3, 0, 2, 16'h0, 16'h0, 0, 0, 0);
    for (int s = 0; s < 4; s++)
      do_op("R6 indexed",  5, 32'h0, 32'h00001000, 32'h5, 32'h3, s, 0, 16'h007E, 16'h0, 0, 0, 0);
    do_op("R11 neg disp",  5, 32'h0, 32'h00001000, 32'h3, 32'h0, 2, 0, 16'hFF80, 16'h0, 0, 0, 0);
    do_op("R11 wrap",      5, 32'h0, 32'hFFFFFFF0, 32'h4, 32'h0, 1, 0, 16'h0018, 16'h0, 0, 0, 0);
    do_op("R7 pc rel",     9, 32'h0, 32'h55555555, 32'h3, 32'h00008000, 2, 0, 16'h0010, 16'h0, 0, 0, 2);
    do_op("R8 mem ind",    6, 32'h0, 32'h00002000, 32'h4, 32'h0, 1, 0, 16'h007E, 16'h001C, 2, 1, 0);
    do_op("R9 post idx",   7, 32'h0, 32'h00002000, 32'h4, 32'h0, 1, 0, 16'h007E, 16'hFFF0, 0, 0, 0);
    do_op("R10 pre idx",   8, 32'h0, 32'h00002000, 32'h4, 32'h0, 2, 0, 16'h007E, 16'h001C, 0, 3, 3);
    do_op("R11 ind neg",   6, 32'h0, 32'h00000010, 32'h0, 32'h0, 0, 0, 16'hFFE0, 16'h8000, 1, 0, 0);
    do_op("R12 stalls",    7, 32'h0, 32'hFFFFFF00, 32'hFFFFFFFF, 32'h0, 3, 0, 16'h0200, 16'h0004, 3, 2, 4);

    mon_on = 0;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule